// File: doc/BRIEF.md
# Pointer Register Address Generator

This block keeps eight 16-bit pointer registers and turns each indirect operand reference into a memory address. In the same cycle it writes the new value back into the pointer named by the reference. Register 0 also acts as the index step. A separate size input sets the length of a circular buffer. The address outputs are combinational from the current pointer and the request fields. Pointer updates take effect at the next rising clock edge.

The single-operand form uses a 4-bit option and a 3-bit pointer select, and may also use a 16-bit constant. It covers these options:
- linear post-stepping by one or by the index;
- circular post-stepping, where the buffer base is the pointer with its low bits cleared;
- reverse-carry stepping for FFT reordering;
- pre-offset by the constant, with the pointer either kept or updated (linearly or circularly);
- an absolute constant address.

The dual-operand form produces two addresses at once through two arithmetic lanes. Each lane uses a 2-bit option and a 2-bit select that picks one of pointers 2 to 5. A write port loads any pointer directly.

Top module: `ptr_agu`

## Requirements
- R1: After reset every pointer register reads 0x0000.
- R2: When `wr_en` is high, the pointer `wr_sel` takes `wr_data` at the next edge. This write overrides any update of the same pointer in that cycle, and updates of other pointers still happen.
- R3: Some single options leave the pointer unchanged. Option 0 gives `addr_a` = pointer. Option 11 gives `addr_a` = pointer + `lk`. Option 14 gives `addr_a` = `lk`.
- R4: Options 1, 2, 3 and 4 give `addr_a` = pointer. The pointer then becomes pointer+1, pointer−1, pointer+P0 or pointer−P0, where P0 is pointer register 0.
- R5: Option 12 gives `addr_a` = pointer + `lk` and stores that sum in the pointer. Option 15 does the same with +1 in place of `lk`.
- R6: Options 5, 6, 7 and 8 give `addr_a` = pointer and step it circularly by +1, −1, +P0 or −P0. Let nb be the bit length of `bk`: nb is 5 when `bk`=30 and 6 when `bk`=32. The buffer base is the pointer with its nb low bits cleared. Within the buffer the offset becomes (offset + step) mod `bk`, so a step past base+`bk`−1 lands on the base and a step below the base lands on base+`bk`−1.
- R7: Option 13 steps the pointer circularly by `lk`, under the rule of R6. It outputs the new value on `addr_a` and stores it.
- R8: When `bk` is 0, the circular options (5–8, 13 and dual option 3) step linearly.
- R9: Options 9 and 10 give `addr_a` = pointer. They then add or subtract P0 with the carry running from the MSB toward the LSB, so with P0=8 the pointer visits 0, 8, 4, 12.
- R10: With `req` and `dual` high, X uses pointer 2+`xsel` and Y uses pointer 2+`ysel`. The two addresses appear on `addr_a` and `addr_b`. Each lane applies its own option: 0 leaves the pointer unchanged, 1 adds one after the access, 2 subtracts one after the access, and 3 adds P0 circularly after the access. Both pointers update in the same cycle.
- R11: If both dual selects name the same pointer, the Y lane's update is the one stored.
- R12: `addr_b` is 0 unless `req` and `dual` are both high. With `req` low, `addr_a` shows pointer `sel` and no pointer changes except through the write port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Address request this cycle |
| dual | input | 1 | Selects the dual-operand form |
| opt | input | 4 | Single-operand option code |
| sel | input | 3 | Single-operand pointer select |
| lk | input | 16 | Constant for offset and absolute options |
| xopt | input | 2 | Dual X lane option |
| xsel | input | 2 | Dual X lane select (pointer 2+xsel) |
| yopt | input | 2 | Dual Y lane option |
| ysel | input | 2 | Dual Y lane select (pointer 2+ysel) |
| bk | input | 16 | Circular buffer length, 0 for linear |
| wr_en | input | 1 | Direct pointer write enable |
| wr_sel | input | 3 | Pointer written |
| wr_data | input | 16 | Value written |
| addr_a | output | 16 | Single address or dual X address |
| addr_b | output | 16 | Dual Y address, else 0 |

## Verification
Two kinds of update can collide on one pointer within a cycle. The first is a dual request whose two lanes name the same pointer. The bench sends X post-increment and Y post-decrement on one register and expects the register to end one below its old value. The second is a direct write landing on the pointer that a post-increment is updating in the same cycle. There the written value must be read back, while the address of that cycle still shows the old pointer. A direct write to register 0 is also paired with an access to another pointer, and both effects must appear.

// File: rtl/ptr_agu_pkg.sv
package ptr_agu_pkg;

    localparam int OPT_W  = 4;
    localparam int DOPT_W = 2;
    localparam int NLANE  = 2;

    typedef enum logic [2:0] {
        K_NONE,
        K_POST_LIN,
        K_POST_CIRC,
        K_POST_REV,
        K_PRE_KEEP,
        K_PRE_UPD,
        K_PRE_CIRC,
        K_ABS
    } step_kind_e;

    typedef enum logic [OPT_W-1:0] {
        S_NOMOD    = 4'd0,
        S_INC      = 4'd1,
        S_DEC      = 4'd2,
        S_ADD_IX   = 4'd3,
        S_SUB_IX   = 4'd4,
        S_INC_C    = 4'd5,
        S_DEC_C    = 4'd6,
        S_ADD_IX_C = 4'd7,
        S_SUB_IX_C = 4'd8,
        S_ADD_REV  = 4'd9,
        S_SUB_REV  = 4'd10,
        S_OFS_KEEP = 4'd11,
        S_OFS_UPD  = 4'd12,
        S_OFS_CIRC = 4'd13,
        S_ABSOLUTE = 4'd14,
        S_PRE_INC  = 4'd15
    } sopt_e;

    typedef enum logic [DOPT_W-1:0] {
        D_NOMOD    = 2'd0,
        D_INC      = 2'd1,
        D_DEC      = 2'd2,
        D_ADD_IX_C = 2'd3
    } dopt_e;

endpackage

// File: rtl/ptr_agu_circ.sv
module ptr_agu_circ #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] step,
    input  logic [AW-1:0] size,
    output logic [AW-1:0] res
);
    localparam int EW = AW + 2;

    logic [AW-1:0]        msk;
    logic [AW-1:0]        off;
    logic signed [EW-1:0] sum;
    logic signed [EW-1:0] lim;
    logic signed [EW-1:0] fix;
    logic [AW-1:0]        fix_l;

    always_comb begin
        msk = '0;
        for (int i = 0; i < AW; i++) begin
            if (size[i]) msk = AW'((EW'(1) << (i + 1)) - EW'(1));
        end
        off = ptr & msk;
        sum = $signed({2'b00, off}) + $signed({{2{step[AW-1]}}, step});
        lim = $signed({2'b00, size});
        if (sum >= lim)       fix = sum - lim;
        else if (sum < 0)     fix = sum + lim;
        else                  fix = sum;
        fix_l = AW'(fix);
        if (size == '0) res = ptr + step;
        else            res = (ptr & ~msk) | (fix_l & msk);
    end

endmodule

// File: rtl/ptr_agu_lane.sv
module ptr_agu_lane import ptr_agu_pkg::*; #(
    parameter int AW = 16
) (
    input  step_kind_e    kind,
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] mag,
    input  logic          neg,
    input  logic [AW-1:0] size,
    output logic [AW-1:0] addr,
    output logic [AW-1:0] nxt,
    output logic          upd
);
    function automatic logic [AW-1:0] flip(input logic [AW-1:0] v);
        logic [AW-1:0] r;
        for (int i = 0; i < AW; i++) r[i] = v[AW-1-i];
        return r;
    endfunction

    logic [AW-1:0] step;
    logic [AW-1:0] lin;
    logic [AW-1:0] circ;
    logic [AW-1:0] rsum;
    logic [AW-1:0] rev;

    assign step = neg ? (~mag + AW'(1)) : mag;
    assign lin  = ptr + step;

    ptr_agu_circ #(.AW(AW)) u_circ (
        .ptr  (ptr),
        .step (step),
        .size (size),
        .res  (circ)
    );

    always_comb begin
        rsum = neg ? (flip(ptr) - flip(mag)) : (flip(ptr) + flip(mag));
        rev  = flip(rsum);
    end

    always_comb begin
        addr = ptr;
        nxt  = ptr;
        upd  = 1'b0;
        unique case (kind)
            K_NONE:      ;
            K_POST_LIN:  begin nxt = lin;  upd = 1'b1; end
            K_POST_CIRC: begin nxt = circ; upd = 1'b1; end
            K_POST_REV:  begin nxt = rev;  upd = 1'b1; end
            K_PRE_KEEP:  addr = lin;
            K_PRE_UPD:   begin addr = lin;  nxt = lin;  upd = 1'b1; end
            K_PRE_CIRC:  begin addr = circ; nxt = circ; upd = 1'b1; end
            K_ABS:       addr = mag;
            default:     ;
        endcase
    end

endmodule

// File: rtl/ptr_agu_dec.sv
module ptr_agu_dec import ptr_agu_pkg::*; #(
    parameter int AW        = 16,
    parameter int SW        = 3,
    parameter int DSW       = 2,
    parameter int DUAL_BASE = 2
) (
    input  logic              req,
    input  logic              dual,
    input  logic [OPT_W-1:0]  opt,
    input  logic [SW-1:0]     sel,
    input  logic [AW-1:0]     lk,
    input  logic [AW-1:0]     ix,
    input  logic [DOPT_W-1:0] xopt,
    input  logic [DSW-1:0]    xsel,
    input  logic [DOPT_W-1:0] yopt,
    input  logic [DSW-1:0]    ysel,
    output step_kind_e        kind [NLANE],
    output logic [SW-1:0]     idx  [NLANE],
    output logic [AW-1:0]     mag  [NLANE],
    output logic              neg  [NLANE]
);
    logic [DOPT_W-1:0] dop [NLANE];
    logic [DSW-1:0]    dsl [NLANE];

    assign dop[0] = xopt;
    assign dop[1] = yopt;
    assign dsl[0] = xsel;
    assign dsl[1] = ysel;

    always_comb begin
        for (int l = 0; l < NLANE; l++) begin
            kind[l] = K_NONE;
            idx[l]  = '0;
            mag[l]  = AW'(1);
            neg[l]  = 1'b0;
        end
        idx[0] = sel;
        if (req && dual) begin
            for (int l = 0; l < NLANE; l++) begin
                idx[l] = SW'(DUAL_BASE) + SW'(dsl[l]);
                unique case (dopt_e'(dop[l]))
                    D_NOMOD:    kind[l] = K_NONE;
                    D_INC:      kind[l] = K_POST_LIN;
                    D_DEC:      begin kind[l] = K_POST_LIN; neg[l] = 1'b1; end
                    D_ADD_IX_C: begin kind[l] = K_POST_CIRC; mag[l] = ix; end
                    default:    kind[l] = K_NONE;
                endcase
            end
        end else if (req) begin
            unique case (sopt_e'(opt))
                S_NOMOD:    kind[0] = K_NONE;
                S_INC:      kind[0] = K_POST_LIN;
                S_DEC:      begin kind[0] = K_POST_LIN; neg[0] = 1'b1; end
                S_ADD_IX:   begin kind[0] = K_POST_LIN; mag[0] = ix; end
                S_SUB_IX:   begin kind[0] = K_POST_LIN; mag[0] = ix; neg[0] = 1'b1; end
                S_INC_C:    kind[0] = K_POST_CIRC;
                S_DEC_C:    begin kind[0] = K_POST_CIRC; neg[0] = 1'b1; end
                S_ADD_IX_C: begin kind[0] = K_POST_CIRC; mag[0] = ix; end
                S_SUB_IX_C: begin kind[0] = K_POST_CIRC; mag[0] = ix; neg[0] = 1'b1; end
                S_ADD_REV:  begin kind[0] = K_POST_REV; mag[0] = ix; end
                S_SUB_REV:  begin kind[0] = K_POST_REV; mag[0] = ix; neg[0] = 1'b1; end
                S_OFS_KEEP: begin kind[0] = K_PRE_KEEP; mag[0] = lk; end
                S_OFS_UPD:  begin kind[0] = K_PRE_UPD; mag[0] = lk; end
                S_OFS_CIRC: begin kind[0] = K_PRE_CIRC; mag[0] = lk; end
                S_ABSOLUTE: begin kind[0] = K_ABS; mag[0] = lk; end
                S_PRE_INC:  kind[0] = K_PRE_UPD;
                default:    kind[0] = K_NONE;
            endcase
        end
    end

endmodule

// File: rtl/ptr_agu.sv
module ptr_agu import ptr_agu_pkg::*; #(
    parameter int AW        = 16,
    parameter int NREG      = 8,
    parameter int SW        = $clog2(NREG),
    parameter int DSW       = 2,
    parameter int DUAL_BASE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              dual,
    input  logic [OPT_W-1:0]  opt,
    input  logic [SW-1:0]     sel,
    input  logic [AW-1:0]     lk,
    input  logic [DOPT_W-1:0] xopt,
    input  logic [DSW-1:0]    xsel,
    input  logic [DOPT_W-1:0] yopt,
    input  logic [DSW-1:0]    ysel,
    input  logic [AW-1:0]     bk,
    input  logic              wr_en,
    input  logic [SW-1:0]     wr_sel,
    input  logic [AW-1:0]     wr_data,
    output logic [AW-1:0]     addr_a,
    output logic [AW-1:0]     addr_b
);
    typedef struct packed {
        logic [NREG-1:0][AW-1:0] ar;
    } agu_state_t;

    agu_state_t st_d, st_q;

    step_kind_e    l_kind [NLANE];
    logic [SW-1:0] l_idx  [NLANE];
    logic [AW-1:0] l_mag  [NLANE];
    logic          l_neg  [NLANE];
    logic [AW-1:0] l_addr [NLANE];
    logic [AW-1:0] l_nxt  [NLANE];
    logic          l_upd  [NLANE];

    ptr_agu_dec #(
        .AW(AW), .SW(SW), .DSW(DSW), .DUAL_BASE(DUAL_BASE)
    ) u_dec (
        .req  (req),
        .dual (dual),
        .opt  (opt),
        .sel  (sel),
        .lk   (lk),
        .ix   (st_q.ar[0]),
        .xopt (xopt),
        .xsel (xsel),
        .yopt (yopt),
        .ysel (ysel),
        .kind (l_kind),
        .idx  (l_idx),
        .mag  (l_mag),
        .neg  (l_neg)
    );

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        ptr_agu_lane #(.AW(AW)) u_lane (
            .kind (l_kind[g]),
            .ptr  (st_q.ar[l_idx[g]]),
            .mag  (l_mag[g]),
            .neg  (l_neg[g]),
            .size (bk),
            .addr (l_addr[g]),
            .nxt  (l_nxt[g]),
            .upd  (l_upd[g])
        );
    end

    assign addr_a = l_addr[0];
    assign addr_b = (req && dual) ? l_addr[1] : '0;

    always_comb begin
        st_d = st_q;
        for (int l = 0; l < NLANE; l++) begin
            if (l_upd[l]) st_d.ar[l_idx[l]] = l_nxt[l];
        end
        if (wr_en) st_d.ar[wr_sel] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/ptr_agu_chk.sv
module ptr_agu_chk #(
    parameter int AW        = 16,
    parameter int NREG      = 8,
    parameter int SW        = 3,
    parameter int DSW       = 2,
    parameter int DUAL_BASE = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    req,
    input logic                    dual,
    input logic [3:0]              opt,
    input logic [SW-1:0]           sel,
    input logic [AW-1:0]           lk,
    input logic [1:0]              xopt,
    input logic [DSW-1:0]          xsel,
    input logic [1:0]              yopt,
    input logic [DSW-1:0]          ysel,
    input logic                    wr_en,
    input logic [SW-1:0]           wr_sel,
    input logic [AW-1:0]           wr_data,
    input logic [AW-1:0]           addr_a,
    input logic [AW-1:0]           addr_b,
    input logic [NREG-1:0][AW-1:0] ar
);
    logic [SW-1:0] xi, yi;
    assign xi = SW'(DUAL_BASE) + SW'(xsel);
    assign yi = SW'(DUAL_BASE) + SW'(ysel);

    a_r2_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ar[$past(wr_sel)] == $past(wr_data));

    a_r3_abs_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !dual && opt == 4'd14) |-> addr_a == lk);

    a_r3_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !dual && (opt == 4'd0 || opt == 4'd11 || opt == 4'd14) && !wr_en)
        |=> ar[$past(sel)] == $past(ar[sel]));

    a_r4_post_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !dual && opt == 4'd1 && !wr_en)
        |=> ar[$past(sel)] == $past(addr_a) + AW'(1));

    a_r10_dual_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (req && dual && xopt == 2'd1 && yopt == 2'd1 && xsel != ysel && !wr_en)
        |=> (ar[$past(xi)] == $past(addr_a) + AW'(1)) && (ar[$past(yi)] == $past(addr_b) + AW'(1)));

    a_r12_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!req && !wr_en) |=> ar == $past(ar));

    a_r12_b_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(req && dual) |-> addr_b == '0);

endmodule

bind ptr_agu ptr_agu_chk #(
    .AW(AW), .NREG(NREG), .SW(SW), .DSW(DSW), .DUAL_BASE(DUAL_BASE)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .dual    (dual),
    .opt     (opt),
    .sel     (sel),
    .lk      (lk),
    .xopt    (xopt),
    .xsel    (xsel),
    .yopt    (yopt),
    .ysel    (ysel),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .addr_a  (addr_a),
    .addr_b  (addr_b),
    .ar      (st_q.ar)
);

// File: tb/ptr_agu_tb.sv
module ptr_agu_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, dual = 1'b0;
    logic [3:0]  opt = '0;
    logic [2:0]  sel = '0;
    logic [15:0] lk = '0;
    logic [1:0]  xopt = '0, xsel = '0, yopt = '0, ysel = '0;
    logic [15:0] bk = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] addr_a, addr_b;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ptr_agu u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .dual(dual), .opt(opt), .sel(sel),
        .lk(lk), .xopt(xopt), .xsel(xsel), .yopt(yopt), .ysel(ysel), .bk(bk),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .addr_a(addr_a), .addr_b(addr_b)
    );

    typedef struct packed {
        logic        req;
        logic        dual;
        logic [3:0]  opt;
        logic [2:0]  sel;
        logic [15:0] lk;
        logic [1:0]  xo, xs, yo, ys;
        logic [15:0] bk;
        logic        we;
        logic [2:0]  ws;
        logic [15:0] wd;
        logic [15:0] ea, eb;
        logic [7:0]  rq;
    } vec_t;

    function automatic vec_t sv(int o, int s, int k, int b, int ea, int rq);
        vec_t v = '0;
        v.req = 1'b1; v.opt = 4'(o); v.sel = 3'(s); v.lk = 16'(k);
        v.bk = 16'(b); v.ea = 16'(ea); v.rq = 8'(rq);
        return v;
    endfunction

    function automatic vec_t dv(int xo, int xs, int yo, int ys, int b, int ea, int eb, int rq);
        vec_t v = '0;
        v.req = 1'b1; v.dual = 1'b1;
        v.xo = 2'(xo); v.xs = 2'(xs); v.yo = 2'(yo); v.ys = 2'(ys);
        v.bk = 16'(b); v.ea = 16'(ea); v.eb = 16'(eb); v.rq = 8'(rq);
        return v;
    endfunction

    function automatic vec_t wv(vec_t b, int s, int d);
        vec_t v = b;
        v.we = 1'b1; v.ws = 3'(s); v.wd = 16'(d);
        return v;
    endfunction

    function automatic vec_t idle(vec_t b);
        vec_t v = b;
        v.req = 1'b0;
        return v;
    endfunction

    localparam int NV = 40;
    localparam vec_t VEC [NV] = '{
        sv(0, 1, 0, 30, 'h0200, 3),                    // R3 no change
        sv(1, 1, 0, 30, 'h0200, 4),                    // R4 post +1
        sv(0, 1, 0, 30, 'h0201, 4),
        sv(4, 1, 0, 30, 'h0201, 4),                    // R4 post -P0
        sv(0, 1, 0, 30, 'h01FF, 4),
        sv(5, 3, 0, 30, 'h021D, 6),                    // R6 wrap past end
        sv(6, 3, 0, 30, 'h0200, 6),                    // R6 wrap below base
        sv(7, 3, 0, 30, 'h021D, 6),                    // R6 +P0 circular
        sv(0, 3, 0, 30, 'h0201, 6),
        sv(11, 4, 5, 30, 'h0105, 3),                   // R3 offset keep
        sv(0, 4, 0, 30, 'h0100, 3),
        sv(12, 4, 'hFFFE, 30, 'h00FE, 5),              // R5 offset update
        sv(15, 4, 0, 30, 'h00FF, 5),                   // R5 pre-increment
        sv(14, 4, 'hBEEF, 30, 'hBEEF, 3),              // R3 absolute
        sv(0, 4, 0, 30, 'h00FF, 3),
        sv(13, 3, 'h001C, 30, 'h021D, 7),              // R7 circular offset
        sv(0, 3, 0, 30, 'h021D, 7),
        wv(sv(0, 6, 0, 30, 'h0000, 2), 0, 'h0008),     // R2 write P0 with access elsewhere
        sv(9, 6, 0, 30, 'h0000, 9),                    // R9 reverse carry
        sv(9, 6, 0, 30, 'h0008, 9),
        sv(9, 6, 0, 30, 'h0004, 9),
        sv(10, 6, 0, 30, 'h000C, 9),
        sv(0, 6, 0, 30, 'h0004, 9),
        sv(7, 7, 0, 0, 'h0008, 8),                     // R8 size 0 linear
        sv(0, 7, 0, 0, 'h0010, 8),
        dv(1, 0, 2, 3, 30, 'h0300, 'h0010, 10),        // R10 dual inc/dec
        dv(0, 0, 0, 3, 30, 'h0301, 'h000F, 10),
        dv(3, 1, 0, 2, 30, 'h021D, 'h00FF, 10),        // R10 dual circular
        dv(0, 1, 0, 2, 30, 'h0207, 'h00FF, 10),
        dv(1, 2, 2, 2, 30, 'h00FF, 'h00FF, 11),        // R11 same pointer
        sv(0, 4, 0, 30, 'h00FE, 11),
        wv(sv(1, 5, 0, 30, 'h000F, 2), 5, 'h1234),     // R2 write beats update
        sv(0, 5, 0, 30, 'h1234, 2),
        idle(sv(1, 5, 0, 30, 'h1234, 12)),             // R12 req low
        sv(0, 5, 0, 30, 'h1234, 12),
        wv(sv(0, 2, 0, 30, 'h0301, 2), 1, 'h015F),
        sv(5, 1, 0, 32, 'h015F, 6),                    // R6 size 32
        sv(0, 1, 0, 32, 'h0140, 6),
        sv(6, 1, 0, 32, 'h0140, 6),
        sv(0, 1, 0, 32, 'h015F, 6)
    };

    task automatic chk(input logic [15:0] got, input logic [15:0] exp, input int rq, input string what);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: got %h expected %h", rq, what, got, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        req = v.req; dual = v.dual; opt = v.opt; sel = v.sel; lk = v.lk;
        xopt = v.xo; xsel = v.xs; yopt = v.yo; ysel = v.ys; bk = v.bk;
        wr_en = v.we; wr_sel = v.ws; wr_data = v.wd;
        #1;
    endtask

    task automatic wr(input int s, input int d);
        vec_t v = '0;
        v.we = 1'b1; v.ws = 3'(s); v.wd = 16'(d);
        apply(v);
    endtask

    task automatic rd(input int s, input int exp, input int rq);
        vec_t v = '0;
        v.sel = 3'(s);
        apply(v);
        chk(addr_a, 16'(exp), rq, "pointer read");
        chk(addr_b, 16'h0000, rq, "addr_b idle");
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) rd(i, 0, 1);          // R1 reset state
        wr(0, 'h0002); wr(1, 'h0200); wr(2, 'h0300); wr(3, 'h021D);
        wr(4, 'h0100); wr(5, 'h0010); wr(6, 'h0000); wr(7, 'h0008);
        rd(3, 'h021D, 2);                                  // R2 write loads
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            chk(addr_a, VEC[i].ea, int'(VEC[i].rq), $sformatf("vector %0d addr_a", i));
            chk(addr_b, VEC[i].eb, int'(VEC[i].rq), $sformatf("vector %0d addr_b", i));
        end
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(1, 0, 1);                                       // R1 after second reset
        rd(5, 0, 1);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule